// File: doc/BRIEF.md
# Cache-Snooping Barrier Filter

This block sits beside the request path of a shared cache controller and turns ordinary coherence traffic into a hardware barrier. Each request seen on the snoop port carries an address, a thread number and a kind: invalidation or line fill. Each address is compared against the barrier addresses programmed through the setup port. A participating thread announces its arrival by invalidating the arrival line. It then stalls because its refill of that line is held back. When the last participant arrives, every participant is released at once and the held fills are granted.

Each participating thread has a small state machine: running, waiting at the barrier, or released. A released thread goes back to running only when it invalidates the exit line. Receiving a fill is not enough, because a thread may fetch the line several times. In alternating mode two arrival lines take turns between successive barriers. An arrival on the current line then also serves as the exit from the previous barrier, so no separate exit invalidation is needed. Traffic that does not concern the barrier is forwarded unchanged on the pass port.

Top module: `barrier_snoop_filter`

## Requirements
- R1: After reset, grant_valid, pass_valid and cfg_err are 0 and the block is unconfigured. While unconfigured, every request is forwarded on the pass port and no grant is made.
- R2: A setup write whose thread count is 1..NUM_THREADS is accepted. It clears the arrival counter, puts every thread into the running state, drops all held fills, selects arrival line A and clears cfg_err. A count of 0 or above NUM_THREADS is rejected: cfg_err goes to 1 and the previous setup stays in force. A request presented in the same cycle as any setup write is discarded.
- R3: An invalidation (req_inval=1) of the current arrival line by a running participant counts one arrival and moves that thread to waiting. An arrival invalidation from a thread already waiting is ignored and is not counted again.
- R4: A fill (req_inval=0) to any barrier line from a waiting thread is not granted. At most one held fill is kept per thread.
- R5: The arrival that brings the count to the programmed thread count resets the counter to 0 and moves every participant to released in the same cycle.
- R6: After a release, held fills are granted one per cycle in ascending thread order. The lowest thread's grant appears on the second rising edge after the releasing arrival is sampled.
- R7: A fill to a barrier line from a thread that is not waiting is granted on the second rising edge after it is sampled, provided no lower-numbered thread has a grant outstanding. grant_tid carries the thread number.
- R8: In normal mode (cfg_alt=0) the barrier lines are arrival line A and the exit line. A released thread returns to running only on an invalidation of the exit line. Fills and arrival-line invalidations leave it released.
- R9: In alternating mode (cfg_alt=1) the barrier lines are A and B. The current arrival line is A after setup and toggles on each release. An invalidation of the current line by a released thread counts as an arrival, and the thread moves straight to waiting. An invalidation of the other line is ignored.
- R10: A request whose address is not a barrier line, or whose thread number is not below the programmed count, changes no state. It appears on the pass outputs, with the same kind, address and thread, one rising edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_count | input | CNT_W | Number of participating threads |
| cfg_alt | input | 1 | 1 selects alternating arrival lines |
| cfg_line_a | input | ADDR_W | Arrival line A |
| cfg_line_b | input | ADDR_W | Arrival line B (alternating mode) |
| cfg_exit | input | ADDR_W | Exit line (normal mode) |
| cfg_err | output | 1 | Last setup write was rejected |
| req_valid | input | 1 | Snooped request present |
| req_inval | input | 1 | 1 = invalidation, 0 = fill |
| req_addr | input | ADDR_W | Request line address |
| req_tid | input | TID_W | Requesting thread |
| grant_valid | output | 1 | A barrier-line fill is granted |
| grant_tid | output | TID_W | Thread receiving the grant |
| pass_valid | output | 1 | Forwarded non-barrier request |
| pass_inval | output | 1 | Kind of the forwarded request |
| pass_addr | output | ADDR_W | Address of the forwarded request |
| pass_tid | output | TID_W | Thread of the forwarded request |

## Verification
The bound checker covers, on every cycle, the behaviour that a few signals can express. The arrival counter stays below the programmed count, and each accepted arrival adds exactly one. A release clears the counter and releases every participant. A rejected setup raises the error flag, an accepted one clears all thread state, and no grant ever goes to a thread that was waiting. The bench scenarios cover what needs history. Duplicate arrivals and arrivals on the inactive alternating line must not trigger an early release. Released threads must stay released through repeated fills until they invalidate the exit line. Held grants must come out in ascending order on consecutive cycles, exactly when the requirements predict.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  typedef enum logic [1:0] {
    TS_RUN    = 2'd0,
    TS_WAIT   = 2'd1,
    TS_FREE   = 2'd2
  } thr_state_e;

  // True when one more arrival reaches the programmed participant count.
  function automatic logic arrival_completes(input int unsigned seen,
                                             input int unsigned total);
    return (seen + 1) == total;
  endfunction

  // True when a setup count lies outside 1..limit.
  function automatic logic count_rejected(input int unsigned cnt,
                                          input int unsigned limit);
    return (cnt == 0) || (cnt > limit);
  endfunction

endpackage

// File: rtl/bsf_addr_match.sv
module bsf_addr_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] line_a,
  input  logic [ADDR_W-1:0] line_b,
  input  logic [ADDR_W-1:0] exit_line,
  input  logic              alt_mode,
  input  logic              phase_b,
  output logic              hit_any,
  output logic              hit_cur,
  output logic              hit_exit
);
  logic [ADDR_W-1:0] cur_line;
  logic              eq_a, eq_b, eq_x;

  always_comb begin
    eq_a     = (addr == line_a);
    eq_b     = (addr == line_b);
    eq_x     = (addr == exit_line);
    cur_line = (alt_mode && phase_b) ? line_b : line_a;
    hit_cur  = (addr == cur_line);
    hit_exit = !alt_mode && eq_x;
    hit_any  = eq_a || (alt_mode ? eq_b : eq_x);
  end
endmodule

// File: rtl/bsf_thread_fsm.sv
module bsf_thread_fsm
  import bsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       participant,
  input  logic       alt_mode,
  input  logic       arr_inval,
  input  logic       exit_inval,
  input  logic       release_all,
  output thr_state_e state,
  output logic       arrive_ok
);
  thr_state_e nxt;

  always_comb begin
    arrive_ok = arr_inval &&
                ((state == TS_RUN) || (state == TS_FREE && alt_mode));
    nxt = state;
    unique case (state)
      TS_RUN:  if (arr_inval) nxt = TS_WAIT;
      TS_WAIT: nxt = TS_WAIT;
      TS_FREE: begin
        if (alt_mode && arr_inval)       nxt = TS_WAIT;
        else if (!alt_mode && exit_inval) nxt = TS_RUN;
      end
      default: nxt = TS_RUN;
    endcase
    if (release_all && participant) nxt = TS_FREE;
    if (clr) nxt = TS_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= TS_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/bsf_grant_arb.sv
module bsf_grant_arb #(
  parameter int N     = 8,
  parameter int TID_W = 3
) (
  input  logic [N-1:0]     pending,
  input  logic [N-1:0]     eligible,
  output logic             pick_valid,
  output logic [TID_W-1:0] pick_tid,
  output logic [N-1:0]     pick_onehot
);
  logic [N-1:0] ready;

  always_comb begin
    ready       = pending & eligible;
    pick_valid  = |ready;
    pick_tid    = '0;
    pick_onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ready[i]) begin
        pick_tid    = TID_W'(i);
        pick_onehot = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/barrier_snoop_filter.sv
module barrier_snoop_filter
  import bsf_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int ADDR_W      = 32,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CNT_W      = $clog2(NUM_THREADS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_alt,
  input  logic [ADDR_W-1:0] cfg_line_a,
  input  logic [ADDR_W-1:0] cfg_line_b,
  input  logic [ADDR_W-1:0] cfg_exit,
  output logic              cfg_err,
  input  logic              req_valid,
  input  logic              req_inval,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TID_W-1:0]  req_tid,
  output logic              grant_valid,
  output logic [TID_W-1:0]  grant_tid,
  output logic              pass_valid,
  output logic              pass_inval,
  output logic [ADDR_W-1:0] pass_addr,
  output logic [TID_W-1:0]  pass_tid
);
  // setup state
  logic [CNT_W-1:0]  total_q;
  logic              alt_q, configured_q, phase_q;
  logic [ADDR_W-1:0] line_a_q, line_b_q, exit_q;
  logic [CNT_W-1:0]  arrived_cnt;
  logic [NUM_THREADS-1:0] pend_q;

  // named internal events
  logic cfg_bad, cfg_take;
  logic req_part, snoop_live, barrier_hit, fill_hit;
  logic hit_any, hit_cur, hit_exit;
  logic arrive_evt, release_evt;
  logic [NUM_THREADS-1:0] part_mask, blocked, released, arrive_vec, eligible;
  logic [NUM_THREADS-1:0] pick_onehot;
  logic                   pick_valid;
  logic [TID_W-1:0]       pick_tid;
  thr_state_e             thr_state [NUM_THREADS];

  always_comb begin
    cfg_bad     = count_rejected(32'(cfg_count), 32'(NUM_THREADS));
    cfg_take    = cfg_we && !cfg_bad;
    req_part    = configured_q && (CNT_W'(req_tid) < total_q);
    snoop_live  = req_valid && !cfg_we && req_part;
    barrier_hit = snoop_live && hit_any;
    fill_hit    = barrier_hit && !req_inval;
    arrive_evt  = |arrive_vec;
    release_evt = arrive_evt &&
                  arrival_completes(32'(arrived_cnt), 32'(total_q));
    eligible    = part_mask & ~blocked;
  end

  bsf_addr_match #(.ADDR_W(ADDR_W)) match_i (
    .addr      (req_addr),
    .line_a    (line_a_q),
    .line_b    (line_b_q),
    .exit_line (exit_q),
    .alt_mode  (alt_q),
    .phase_b   (phase_q),
    .hit_any   (hit_any),
    .hit_cur   (hit_cur),
    .hit_exit  (hit_exit)
  );

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    logic tid_sel;
    assign tid_sel      = (req_tid == TID_W'(g));
    assign part_mask[g] = configured_q && (CNT_W'(g) < total_q);

    bsf_thread_fsm fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (cfg_take),
      .participant (part_mask[g]),
      .alt_mode    (alt_q),
      .arr_inval   (snoop_live && req_inval && hit_cur && tid_sel),
      .exit_inval  (snoop_live && req_inval && hit_exit && tid_sel),
      .release_all (release_evt),
      .state       (thr_state[g]),
      .arrive_ok   (arrive_vec[g])
    );

    assign blocked[g]  = (thr_state[g] == TS_WAIT);
    assign released[g] = (thr_state[g] == TS_FREE);
  end

  bsf_grant_arb #(.N(NUM_THREADS), .TID_W(TID_W)) arb_i (
    .pending     (pend_q),
    .eligible    (eligible),
    .pick_valid  (pick_valid),
    .pick_tid    (pick_tid),
    .pick_onehot (pick_onehot)
  );

  // setup registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q      <= '0;
      alt_q        <= 1'b0;
      configured_q <= 1'b0;
      line_a_q     <= '0;
      line_b_q     <= '0;
      exit_q       <= '0;
      cfg_err      <= 1'b0;
    end else if (cfg_we) begin
      cfg_err <= cfg_bad;
      if (!cfg_bad) begin
        total_q      <= cfg_count;
        alt_q        <= cfg_alt;
        configured_q <= 1'b1;
        line_a_q     <= cfg_line_a;
        line_b_q     <= cfg_line_b;
        exit_q       <= cfg_exit;
      end
    end
  end

  // arrival counter and alternating phase
  always_ff @(posedge clk) begin
    if (!rst_n || cfg_take) begin
      arrived_cnt <= '0;
      phase_q     <= 1'b0;
    end else if (release_evt) begin
      arrived_cnt <= '0;
      phase_q     <= alt_q ? !phase_q : phase_q;
    end else if (arrive_evt) begin
      arrived_cnt <= arrived_cnt + 1'b1;
    end
  end

  // held fill flags and grant register
  always_ff @(posedge clk) begin
    if (!rst_n || cfg_take) begin
      pend_q      <= '0;
      grant_valid <= 1'b0;
      grant_tid   <= '0;
    end else begin
      pend_q <= (pend_q & ~(pick_valid ? pick_onehot : '0)) |
                (fill_hit ? (NUM_THREADS'(1) << req_tid) : '0);
      grant_valid <= pick_valid;
      grant_tid   <= pick_tid;
    end
  end

  // forwarding of traffic that does not concern the barrier
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_valid <= 1'b0;
      pass_inval <= 1'b0;
      pass_addr  <= '0;
      pass_tid   <= '0;
    end else begin
      pass_valid <= req_valid && !cfg_we && !barrier_hit;
      pass_inval <= req_inval;
      pass_addr  <= req_addr;
      pass_tid   <= req_tid;
    end
  end

endmodule

module bsf_checker #(
  parameter int N     = 8,
  parameter int CNT_W = 4,
  parameter int TID_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_bad,
  input logic             cfg_take,
  input logic             cfg_err,
  input logic             configured,
  input logic [CNT_W-1:0] total,
  input logic [CNT_W-1:0] arrived_cnt,
  input logic             arrive_evt,
  input logic             release_evt,
  input logic [N-1:0]     blocked,
  input logic [N-1:0]     released,
  input logic [N-1:0]     part_mask,
  input logic             grant_valid,
  input logic [TID_W-1:0] grant_tid
);
  logic [N-1:0] blk_q;
  always_ff @(posedge clk) begin
    if (!rst_n) blk_q <= '0;
    else        blk_q <= blocked;
  end

  // R3
  cnt_below_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    configured |-> arrived_cnt < total);

  // R3
  arrive_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive_evt && !release_evt) |=> arrived_cnt == CNT_W'($past(arrived_cnt) + 1'b1));

  // R5
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (arrived_cnt == '0) &&
                    ((released & $past(part_mask)) == $past(part_mask)));

  // R2
  bad_setup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_bad) |=> cfg_err);

  // R2
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |=> (arrived_cnt == '0) && (blocked == '0) && !cfg_err);

  // R4
  no_grant_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !blk_q[grant_tid]);
endmodule

bind barrier_snoop_filter bsf_checker #(
  .N(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_bad     (cfg_bad),
  .cfg_take    (cfg_take),
  .cfg_err     (cfg_err),
  .configured  (configured_q),
  .total       (total_q),
  .arrived_cnt (arrived_cnt),
  .arrive_evt  (arrive_evt),
  .release_evt (release_evt),
  .blocked     (blocked),
  .released    (released),
  .part_mask   (part_mask),
  .grant_valid (grant_valid),
  .grant_tid   (grant_tid)
);

// File: tb/barrier_snoop_filter_tb_top.sv
module barrier_snoop_filter_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int TW = 3;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_alt = 1'b0;
  logic [CW-1:0] cfg_count = '0;
  logic [AW-1:0] cfg_line_a = '0, cfg_line_b = '0, cfg_exit = '0;
  logic cfg_err;
  logic req_valid = 1'b0, req_inval = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tid = '0;
  logic grant_valid, pass_valid, pass_inval;
  logic [TW-1:0] grant_tid, pass_tid;
  logic [AW-1:0] pass_addr;

  always #2 clk = ~clk;

  barrier_snoop_filter #(.NUM_THREADS(N), .ADDR_W(AW)) dut_i (.*);

  typedef struct { int tid; int due; } gexp_t;
  typedef struct { logic inv; logic [AW-1:0] addr; int tid; int due; } pexp_t;
  gexp_t gq[$];
  pexp_t pq[$];
  int cyc = 0, checks = 0, errors = 0, last_c = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: %s", req, msg); end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && !done) begin
    if (gq.size() > 0 && gq[0].due == cyc) begin
      check(grant_valid && int'(grant_tid) == gq[0].tid, "R6/R7",
            $sformatf("grant v=%0d tid=%0d exp tid=%0d at cyc %0d",
                      grant_valid, grant_tid, gq[0].tid, cyc));
      void'(gq.pop_front());
    end else if (grant_valid) begin
      check(0, "R4", $sformatf("unexpected grant tid=%0d exp none", grant_tid));
    end
    if (pq.size() > 0 && pq[0].due == cyc) begin
      check(pass_valid && pass_inval == pq[0].inv && pass_addr == pq[0].addr &&
            int'(pass_tid) == pq[0].tid, "R10",
            $sformatf("pass v=%0d addr=%h tid=%0d exp addr=%h tid=%0d",
                      pass_valid, pass_addr, pass_tid, pq[0].addr, pq[0].tid));
      void'(pq.pop_front());
    end else if (pass_valid) begin
      check(0, "R10", $sformatf("unexpected pass addr=%h exp none", pass_addr));
    end
  end

  task automatic send(input logic inv, input logic [AW-1:0] a, input int t);
    @(negedge clk);
    req_valid = 1'b1; req_inval = inv; req_addr = a; req_tid = TW'(t);
    last_c = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sendp(input logic inv, input logic [AW-1:0] a, input int t);
    send(inv, a, t);
    pq.push_back('{inv, a, t, last_c + 1});
  endtask

  task automatic exp_grant(input int t, input int off);
    gq.push_back('{t, last_c + 2 + off});
  endtask

  task automatic setup(input int cnt, input logic alt, input logic [AW-1:0] a,
                       input logic [AW-1:0] b, input logic [AW-1:0] x);
    @(negedge clk);
    cfg_we = 1'b1; cfg_count = CW'(cnt); cfg_alt = alt;
    cfg_line_a = a; cfg_line_b = b; cfg_exit = x;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
    check(gq.size() == 0 && pq.size() == 0, "R6",
          $sformatf("queues left g=%0d p=%0d exp 0", gq.size(), pq.size()));
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!grant_valid && !pass_valid && !cfg_err, "R1",
          $sformatf("g=%0d p=%0d e=%0d exp 0 0 0", grant_valid, pass_valid, cfg_err));
    // R1 unconfigured forwards everything
    sendp(1'b0, 32'h100, 0);
    sendp(1'b1, 32'h100, 0);
    settle();

    // R2 rejected counts
    setup(0, 1'b0, 32'h100, 32'h0, 32'h200);
    check(cfg_err, "R2", $sformatf("err=%0d exp 1 for count 0", cfg_err));
    setup(N + 1, 1'b0, 32'h100, 32'h0, 32'h200);
    check(cfg_err, "R2", $sformatf("err=%0d exp 1 for count %0d", cfg_err, N + 1));
    sendp(1'b0, 32'h100, 1);  // still unconfigured, so forwarded
    setup(3, 1'b0, 32'h100, 32'h0, 32'h200);
    check(!cfg_err, "R2", $sformatf("err=%0d exp 0", cfg_err));

    // R10 non-barrier line forwarded
    sendp(1'b0, 32'h40, 1);
    sendp(1'b1, 32'h44, 2);

    // R3 R4 arrivals and held fills, duplicate arrival ignored
    send(1'b1, 32'h100, 0);
    send(1'b0, 32'h100, 0);
    send(1'b1, 32'h100, 0);
    send(1'b1, 32'h100, 2);
    send(1'b0, 32'h100, 2);
    settle();
    // R5 R6 last arrival releases, grants ascending on consecutive cycles
    send(1'b1, 32'h100, 1);
    exp_grant(0, 0); exp_grant(2, 1);
    settle();

    // R7 R8 released thread fills granted repeatedly and stays released
    send(1'b0, 32'h100, 1); exp_grant(1, 0);
    send(1'b0, 32'h100, 1); exp_grant(1, 0);
    send(1'b1, 32'h100, 2);
    send(1'b0, 32'h100, 2); exp_grant(2, 0);
    send(1'b1, 32'h200, 0);
    send(1'b1, 32'h200, 1);
    send(1'b1, 32'h100, 0);
    send(1'b1, 32'h100, 1);
    send(1'b1, 32'h100, 2);     // R8 ignored: thread 2 has not exited
    send(1'b0, 32'h100, 0);     // held
    settle();
    send(1'b1, 32'h200, 2);
    send(1'b1, 32'h100, 2); exp_grant(0, 0);
    settle();

    // R9 alternating lines
    setup(2, 1'b1, 32'h300, 32'h340, 32'h200);
    send(1'b1, 32'h300, 0);
    send(1'b1, 32'h300, 1);
    send(1'b1, 32'h340, 0);
    send(1'b1, 32'h300, 1);     // R9 inactive line ignored
    send(1'b0, 32'h340, 0);     // held
    send(1'b0, 32'h300, 1); exp_grant(1, 0);
    settle();
    send(1'b1, 32'h340, 1); exp_grant(0, 0);
    settle();
    // R10 thread outside participant range forwarded
    sendp(1'b0, 32'h300, 5);
    // exit line is not a barrier line in alternating mode
    sendp(1'b1, 32'h200, 0);

    // R2 setup drops held fill and returns thread to running
    send(1'b1, 32'h300, 0);
    send(1'b0, 32'h300, 0);
    setup(2, 1'b1, 32'h300, 32'h340, 32'h200);
    send(1'b0, 32'h300, 0); exp_grant(0, 0);
    setup(0, 1'b1, 32'h500, 32'h540, 32'h200);
    check(cfg_err, "R2", $sformatf("err=%0d exp 1", cfg_err));
    send(1'b0, 32'h300, 0); exp_grant(0, 0);  // old setup still in force
    settle();
    finish_run();
  end
endmodule